// File: doc/BRIEF.md
# Byte-Lane Error-Correcting Static Memory

This block is a word-addressed 16-bit static memory made of two independent 8-bit byte lanes. Each lane keeps its own 4 check bits beside its 8 data bits, so every stored lane word is 12 bits. On a read, each lane repairs any single flipped bit in its own stored word before the data reaches the outputs. Apart from a per-lane "corrected" pulse, the repair cannot be seen at the interface, which behaves like a plain 16-bit memory.

The controls follow the usual asynchronous-memory convention: active-low chip enable, output enable, write enable and a select for each byte. All controls are sampled on a clock edge, so the block synthesizes to ordinary flops and arrays. A byte write encodes only the lane it selects, and needs no read-modify-write. Read data and the per-lane drive enables are registered, so they appear one cycle after the request. A test-only port XORs a mask into one stored lane word, which lets the bench create stored faults.

Top module: `lane_ecc_sram`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rdata`, `rdata_oe` and `corr` are all zero.
- R2: A cycle with `ce_n`=0 and `we_n`=0 stores `wdata` into each lane whose select is low. A lane whose select is high keeps its previous contents.
- R3: A cycle with `ce_n`=0, `we_n`=1 and `oe_n`=0 is a read. One cycle later, each selected lane shows its stored byte on `rdata` and has its `rdata_oe` bit set. An unselected or idle lane shows zero data with its enable clear.
- R4: With `ce_n`=1, nothing is written and nothing is driven. With `oe_n`=1 and `we_n`=1, nothing is driven.
- R5: `lb_n` controls lane 0, which is `wdata`/`rdata` bits 7:0 and `rdata_oe[0]`/`corr[0]`. `ub_n` controls lane 1, which is bits 15:8 and `rdata_oe[1]`/`corr[1]`.
- R6: Flipping any one of a lane word's 12 stored bits still returns the written byte, and `corr` for that lane is 1 in the same cycle as the read data. `corr` is never set for a lane that is not driven.
- R7: A read does not repair the stored word. A second read of the same damaged word pulses `corr` again.
- R8: A stored error in one lane changes neither the data nor the `corr` bit of the other lane.
- R9: Writing a lane re-encodes it. Once written, that lane reads without a `corr` pulse, even if a stored error was present before the write.
- R10: When `inj_en`=1 at a clock edge, `inj_mask` is XORed into the stored 12-bit word at lane `inj_lane` and address `inj_addr`. A read in the same cycle still sees the word as it was before the XOR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output registers |
| addr | input | ADDR_W | Word address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| ub_n | input | 1 | Upper byte (lane 1) select, active low |
| lb_n | input | 1 | Lower byte (lane 0) select, active low |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered; an undriven lane reads zero |
| rdata_oe | output | 2 | Per-lane drive enable, where a pad buffer would turn on |
| corr | output | 2 | Per-lane single-cycle pulse: a stored bit was repaired |
| inj_en | input | 1 | Fault-injection strobe |
| inj_lane | input | 1 | Lane targeted by injection |
| inj_addr | input | ADDR_W | Word targeted by injection |
| inj_mask | input | 12 | Bits to flip in the stored lane word |

## Verification
The bench uses the default `ADDR_W` of 10, so the array holds 1024 words. That depth is small enough for the bench to write every word at start-up, which means no read ever returns uninitialised contents. The small depth also makes random addresses collide often. As a result, injections, repeated reads and overwrites of the same damaged word all occur in the random phase. Directed steps cover injection at each of the 12 bit positions in both lanes, which reaches every nonzero syndrome the code can produce from a single flip.

// File: rtl/lane_ecc_sram.sv
module lane_ecc_sram #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic [1:0]        rdata_oe,
  output logic [1:0]        corr,
  input  logic              inj_en,
  input  logic              inj_lane,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [11:0]       inj_mask
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = 12;
  localparam int DPOS [8] = '{2, 4, 5, 6, 8, 9, 10, 11};

  function automatic logic [CW-1:0] enc(input logic [7:0] d);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < 8; i++) c[DPOS[i]] = d[i];
    for (int b = 0; b < 4; b++)
      for (int p = 1; p <= CW; p++)
        if (((p & (1 << b)) != 0) && (p != (1 << b)))
          c[(1 << b) - 1] = c[(1 << b) - 1] ^ c[p-1];
    return c;
  endfunction

  function automatic logic [3:0] syn(input logic [CW-1:0] c);
    logic [3:0] s;
    s = '0;
    for (int p = 1; p <= CW; p++)
      if (c[p-1]) s = s ^ 4'(p);
    return s;
  endfunction

  function automatic logic [7:0] dec(input logic [CW-1:0] c);
    logic [3:0]    s;
    logic [CW-1:0] f;
    logic [7:0]    d;
    s = syn(c);
    f = c;
    if (s != 4'd0 && s <= 4'd12) f[int'(s) - 1] = ~f[int'(s) - 1];
    for (int i = 0; i < 8; i++) d[i] = f[DPOS[i]];
    return d;
  endfunction

  logic [CW-1:0] mem [2][DEPTH];
  logic [1:0]    sel;
  logic          rd, wr;

  assign sel = ~{ub_n, lb_n};
  assign rd  = !ce_n && we_n && !oe_n;
  assign wr  = !ce_n && !we_n;

  always_ff @(posedge clk) begin
    if (inj_en) mem[inj_lane][inj_addr] <= mem[inj_lane][inj_addr] ^ inj_mask;
    if (wr)
      for (int l = 0; l < 2; l++)
        if (sel[l]) mem[l][addr] <= enc(wdata[8*l +: 8]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rdata_oe <= '0;
      corr     <= '0;
    end else begin
      rdata    <= '0;
      rdata_oe <= '0;
      corr     <= '0;
      if (rd)
        for (int l = 0; l < 2; l++)
          if (sel[l]) begin
            rdata[8*l +: 8] <= dec(mem[l][addr]);
            rdata_oe[l]     <= 1'b1;
            corr[l]         <= syn(mem[l][addr]) != 4'd0;
          end
    end
  end
endmodule

// File: rtl/lane_ecc_sram_chk.sv
module lane_ecc_sram_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ce_n,
  input logic        oe_n,
  input logic        we_n,
  input logic        ub_n,
  input logic        lb_n,
  input logic [15:0] rdata,
  input logic [1:0]  rdata_oe,
  input logic [1:0]  corr
);
  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_oe != 2'b00) |-> $past(!ce_n && we_n && !oe_n)); // R3
  AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe[1] |-> (rdata[15:8] == 8'h00)); // R3
  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n) |-> (rdata_oe == 2'b00)); // R4
  AST_LOW_LANE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe[0] |-> $past(!lb_n)); // R5
  AST_HIGH_LANE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe[1] |-> $past(!ub_n)); // R5
  AST_CORR_ON_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (corr & ~rdata_oe) == 2'b00); // R6
endmodule

bind lane_ecc_sram lane_ecc_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
  .ub_n(ub_n), .lb_n(lb_n), .rdata(rdata), .rdata_oe(rdata_oe), .corr(corr)
);

// File: tb/tb_lane_ecc_sram.sv
`timescale 1ns/1ps
module tb_lane_ecc_sram;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, ub_n = 1'b1, lb_n = 1'b1;
  logic [15:0]       wdata = '0;
  logic [15:0]       rdata;
  logic [1:0]        rdata_oe, corr;
  logic              inj_en = 1'b0, inj_lane = 1'b0;
  logic [ADDR_W-1:0] inj_addr = '0;
  logic [11:0]       inj_mask = '0;

  lane_ecc_sram #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .ub_n(ub_n), .lb_n(lb_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe),
    .corr(corr), .inj_en(inj_en), .inj_lane(inj_lane), .inj_addr(inj_addr),
    .inj_mask(inj_mask)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  string req = "R1";

  logic [7:0]  mdl_data [2][DEPTH];
  logic [11:0] mdl_mask [2][DEPTH];
  logic [15:0] exp_rdata = '0;
  logic [1:0]  exp_oe = '0, exp_corr = '0;

  // reference model: evaluated on each rising edge from the inputs held since the last falling edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      exp_rdata = '0; exp_oe = '0; exp_corr = '0;
    end else begin
      exp_rdata = '0; exp_oe = '0; exp_corr = '0;
      if (!ce_n && we_n && !oe_n)
        for (int l = 0; l < 2; l++)
          if (!(l == 0 ? lb_n : ub_n)) begin
            exp_oe[l] = 1'b1;
            exp_rdata[8*l +: 8] = mdl_data[l][addr];
            exp_corr[l] = mdl_mask[l][addr] != 12'h000;
          end
      if (inj_en) mdl_mask[inj_lane][inj_addr] = mdl_mask[inj_lane][inj_addr] ^ inj_mask;
      if (!ce_n && !we_n)
        for (int l = 0; l < 2; l++)
          if (!(l == 0 ? lb_n : ub_n)) begin
            mdl_data[l][addr] = wdata[8*l +: 8];
            mdl_mask[l][addr] = '0;
          end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  always @(negedge clk) begin
    checks += 3;
    if (rdata_oe !== exp_oe) begin
      fails++;
      $display("FAIL %s rdata_oe actual=%b expected=%b", req, rdata_oe, exp_oe);
    end
    if (rdata !== exp_rdata) begin
      fails++;
      $display("FAIL %s rdata actual=%h expected=%h", req, rdata, exp_rdata);
    end
    if (corr !== exp_corr) begin
      fails++;
      $display("FAIL %s corr actual=%b expected=%b", req, corr, exp_corr);
    end
  end

  task automatic op(input logic c, input logic o, input logic w, input logic u,
                    input logic lo, input int a, input logic [15:0] d);
    ce_n = c; oe_n = o; we_n = w; ub_n = u; lb_n = lo;
    addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
  endtask

  task automatic rd(input int a, input logic u, input logic lo);
    op(1'b0, 1'b0, 1'b1, u, lo, a, 16'h0);
  endtask

  task automatic wr(input int a, input logic u, input logic lo, input logic [15:0] d);
    op(1'b0, 1'b1, 1'b0, u, lo, a, d);
  endtask

  task automatic inject(input int a, input logic l, input logic [11:0] m);
    inj_en = 1'b1; inj_lane = l; inj_addr = ADDR_W'(a); inj_mask = m;
    op(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 0, 16'h0);
    inj_en = 1'b0; inj_mask = '0;
  endtask

  initial begin
    for (int l = 0; l < 2; l++)
      for (int a = 0; a < DEPTH; a++) begin
        mdl_data[l][a] = '0; mdl_mask[l][a] = '0;
      end
    req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    req = "R2";
    for (int a = 0; a < DEPTH; a++) wr(a, 1'b0, 1'b0, 16'($urandom));
    wr(5, 1'b0, 1'b0, 16'hA55A);
    wr(5, 1'b1, 1'b0, 16'h1234);
    rd(5, 1'b0, 1'b0);
    wr(6, 1'b0, 1'b1, 16'hBEEF);
    rd(6, 1'b0, 1'b0);

    req = "R5";
    rd(5, 1'b0, 1'b1);
    rd(5, 1'b1, 1'b0);
    rd(5, 1'b1, 1'b1);

    req = "R4";
    op(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 5, 16'hFFFF);
    rd(5, 1'b0, 1'b0);
    op(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5, 16'h0);
    op(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 5, 16'h0);

    req = "R6";
    for (int l = 0; l < 2; l++)
      for (int b = 0; b < 12; b++) begin
        inject(7, l[0], 12'(1 << b));
        rd(7, 1'b0, 1'b0);
        inject(7, l[0], 12'(1 << b));
        rd(7, 1'b0, 1'b0);
      end

    req = "R7";
    inject(9, 1'b0, 12'h004);
    rd(9, 1'b0, 1'b0);
    rd(9, 1'b0, 1'b0);

    req = "R8";
    inject(11, 1'b1, 12'h800);
    rd(11, 1'b0, 1'b0);
    rd(11, 1'b1, 1'b0);

    req = "R9";
    wr(9, 1'b1, 1'b0, 16'h00C3);
    rd(9, 1'b0, 1'b0);
    wr(11, 1'b0, 1'b1, 16'h7700);
    rd(11, 1'b0, 1'b0);

    req = "R10";
    inj_en = 1'b1; inj_lane = 1'b0; inj_addr = ADDR_W'(13); inj_mask = 12'h020;
    rd(13, 1'b0, 1'b0);
    inj_en = 1'b0; inj_mask = '0;
    rd(13, 1'b0, 1'b0);

    for (int i = 0; i < 4000; i++) begin
      int a, k;
      logic [1:0] s;
      a = int'($urandom % DEPTH);
      k = int'($urandom % 8);
      s = 2'($urandom);
      if (k <= 2) rd(a, s[1], s[0]);
      else if (k <= 4) wr(a, s[1], s[0], 16'($urandom));
      else if (k == 5) op(1'b1, s[0], s[1], 1'b0, 1'b0, a, 16'($urandom));
      else if (k == 6 && mdl_mask[s[0]][a] == 12'h000)
        inject(a, s[0], 12'(1 << ($urandom % 12)));
      else op(1'b0, 1'b1, 1'b1, s[1], s[0], a, 16'h0);
    end
    rd(0, 1'b1, 1'b1);
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule